// File: doc/BRIEF.md
# Parallel Flash Command Sequence Interpreter

This block is the command front end of a small parallel NOR-style flash memory model. On every clock it looks at the active-low chip-enable, output-enable and write-enable strobes together with the address and data buses, and it decides whether the bus is doing a read, a command write or nothing. A state machine follows the multi-write unlock handshakes, and each completed handshake moves the block into one of four modes: plain array reads, identification reads, a single standard program, or a fast program mode that skips the unlock writes.

Reads are answered in the same cycle from a small internal word array. In identification mode they are answered from two fixed ID words instead. A program can only clear bits, so the stored word becomes the AND of its old value and the written data. Erase, program timing, sector protection and voltage levels are not modelled.

Top module: `nor_cmd_if`

## Requirements
- R1: A cycle is a read only when ceN=0, oeN=0 and weN=1. In that cycle dataOutEn is 1 and dataOut carries the read value. In every other cycle dataOutEn is 0 and dataOut is zero.
- R2: After reset the block is in array-read mode, and every array word reads as all ones with no command written first.
- R3: The three writes AA@0x555, 55@0x2AA, 90@0x555 enter identification mode. In that mode a read at address 0 returns MFR_ID (default 0x01), a read at address 1 returns DEV_ID (default 0x7E), and a read at any other address returns zero.
- R4: Identification mode is left only by a write of data F0 to any address, which returns the block to array reads. Every other write in that mode has no effect.
- R5: A standard program takes four writes: AA@0x555, 55@0x2AA, A0@0x555, then the target address and data. The array word is selected by the low log2(DEPTH) address bits. Afterwards the block is back in array-read mode.
- R6: A program stores the bitwise AND of the old word and the written data.
- R7: The writes AA@0x555, 55@0x2AA, 20@0x555 enter fast-program mode. In that mode a program is A0 to any address followed by the target address and data. Reads in that mode return array contents.
- R8: Fast-program mode is left only by the write pair 90 (any address) then 00 (any address). A 90 followed by anything else returns to fast-program mode. F0 has no effect in that mode.
- R9: In a sequence started from array-read mode, a write that does not match the expected step ends the sequence, and the block returns to array-read mode without programming.
- R10: A write of data F0 at any step of a sequence started from array-read mode, including the data step of a standard program, returns the block to array-read mode and programs nothing.
- R11: A cycle with weN=0 that does not also have ceN=0 and oeN=1 is not a write and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset: array-read mode and an all-ones array |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Bus address |
| dataIn | input | DATA_W | Write data and command code |
| dataOut | output | DATA_W | Read data, zero when no read is in progress |
| dataOutEn | output | 1 | High while a read cycle is driving dataOut |

## Verification
A wrong sequence state cannot be seen until a later read or program shows it. A missed identification entry shows up at the next read of address 0 or 1, which returns array data instead of an ID word. A bad program state shows up when a read of the target word returns the wrong AND result, or shows a change where none was allowed. Because a fault may only appear several bus operations later, the bench reads back after every directed sequence, and the random phase compares every read against a mode and array model.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_U1, M_U2, M_PROG, M_AUTO, M_BYP, M_BPROG, M_BEXIT
  } mode_e;

  typedef struct packed {
    logic progEn;
    logic idMode;
  } ctrl_t;

  localparam logic [10:0] UNLOCK_A = 11'h555;
  localparam logic [10:0] UNLOCK_B = 11'h2AA;
  localparam logic [7:0] CMD_K1    = 8'hAA;
  localparam logic [7:0] CMD_K2    = 8'h55;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_BYP   = 8'h20;
  localparam logic [7:0] CMD_RST   = 8'hF0;
  localparam logic [7:0] CMD_BEXIT = 8'h00;
endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output ctrl_t             strb,
  output mode_e             curMode
);
  logic wrCyc, atA, atB;
  logic [7:0] cmd;
  mode_e nxtMode;

  assign wrCyc = !ceN && !weN && oeN;
  assign cmd   = dataIn[7:0];
  assign atA   = addr[10:0] == UNLOCK_A;
  assign atB   = addr[10:0] == UNLOCK_B;

  always_comb begin
    nxtMode = curMode;
    if (wrCyc) begin
      unique case (curMode)
        M_READ:  nxtMode = (atA && cmd == CMD_K1) ? M_U1 : M_READ;
        M_U1:    nxtMode = (atB && cmd == CMD_K2) ? M_U2 : M_READ;
        M_U2: begin
          if (atA && cmd == CMD_ID)        nxtMode = M_AUTO;
          else if (atA && cmd == CMD_PROG) nxtMode = M_PROG;
          else if (atA && cmd == CMD_BYP)  nxtMode = M_BYP;
          else                             nxtMode = M_READ;
        end
        M_PROG:  nxtMode = M_READ;
        M_AUTO:  nxtMode = (cmd == CMD_RST) ? M_READ : M_AUTO;
        M_BYP: begin
          if (cmd == CMD_PROG)    nxtMode = M_BPROG;
          else if (cmd == CMD_ID) nxtMode = M_BEXIT;
          else                    nxtMode = M_BYP;
        end
        M_BPROG: nxtMode = M_BYP;
        M_BEXIT: nxtMode = (cmd == CMD_BEXIT) ? M_READ : M_BYP;
        default: nxtMode = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= M_READ;
    else       curMode <= nxtMode;
  end

  always_comb begin
    strb.idMode = curMode == M_AUTO;
    strb.progEn = wrCyc && ((curMode == M_PROG && cmd != CMD_RST) || curMode == M_BPROG);
  end
endmodule

// File: rtl/nor_cmd_array.sv
module nor_cmd_array
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter logic [DATA_W-1:0] MFR_ID = 'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrl_t             strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] idWord, rdWord;

  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.progEn) begin
      mem[idx] <= mem[idx] & dataIn;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(0))      idWord = MFR_ID;
    else if (addr == ADDR_W'(1)) idWord = DEV_ID;
    else                         idWord = '0;
    rdWord    = strb.idMode ? idWord : mem[idx];
    dataOutEn = !ceN && !oeN && weN;
    dataOut   = dataOutEn ? rdWord : '0;
  end
endmodule

// File: rtl/nor_cmd_if.sv
module nor_cmd_if
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter logic [DATA_W-1:0] MFR_ID = 'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  ctrl_t ctlStrb;
  mode_e curMode;

  nor_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .strb(ctlStrb), .curMode(curMode)
  );

  nor_cmd_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_array (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .strb(ctlStrb),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/nor_cmd_if_checker.sv
module nor_cmd_if_checker
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input ctrl_t             ctlStrb,
  input mode_e             curMode
);
  logic wr;
  assign wr = !ceN && !weN && oeN;

  // R1: no read cycle means a quiet output
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0);
  // R1: output enable only during a read strobe pattern
  a_r1_en_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (!ceN && !oeN && weN));
  // R4: identification mode holds until F0
  a_r4_auto_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == M_AUTO && !(wr && dataIn[7:0] == CMD_RST)) |=> curMode == M_AUTO);
  // R11: non-write cycles change no mode
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wr |=> $stable(curMode));
  // R5: array changes only on the data step of a program
  a_r5_prog_step: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.progEn |-> (wr && (curMode == M_PROG || curMode == M_BPROG)));
  // R8: fast-program mode is kept across any single write
  a_r8_bypass_kept: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode == M_BYP || curMode == M_BPROG) && wr) |=>
      (curMode == M_BYP || curMode == M_BPROG || curMode == M_BEXIT));
endmodule

bind nor_cmd_if nor_cmd_if_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
  .ctlStrb(ctlStrb), .curMode(curMode)
);

// File: tb/nor_cmd_if_bench.sv
module nor_cmd_if_bench;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam logic [7:0] MFR = 8'h01;
  localparam logic [7:0] DEV = 8'h7E;
  localparam int S_READ = 0, S_U1 = 1, S_U2 = 2, S_PROG = 3,
                 S_AUTO = 4, S_BYP = 5, S_BPROG = 6, S_BEXIT = 7;

  logic clk = 0, rstN = 0, ceN = 1, oeN = 1, weN = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOutEn;

  int checks = 0, fails = 0;
  int st = S_READ;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  nor_cmd_if u_nor_cmd_if (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [7:0] expRead(logic [ADDR_W-1:0] a);
    if (st == S_AUTO) return (a == 0) ? MFR : (a == 1) ? DEV : 8'h00;
    return model[a[5:0]];
  endfunction

  function automatic void modelWrite(logic [ADDR_W-1:0] a, logic [7:0] d);
    case (st)
      S_READ:  st = (a == 11'h555 && d == 8'hAA) ? S_U1 : S_READ;
      S_U1:    st = (a == 11'h2AA && d == 8'h55) ? S_U2 : S_READ;
      S_U2:    st = (a != 11'h555) ? S_READ : (d == 8'h90) ? S_AUTO :
                    (d == 8'hA0) ? S_PROG : (d == 8'h20) ? S_BYP : S_READ;
      S_PROG:  begin if (d != 8'hF0) model[a[5:0]] &= d; st = S_READ; end
      S_AUTO:  if (d == 8'hF0) st = S_READ;
      S_BYP:   st = (d == 8'hA0) ? S_BPROG : (d == 8'h90) ? S_BEXIT : S_BYP;
      S_BPROG: begin model[a[5:0]] &= d; st = S_BYP; end
      default: st = (d == 8'h00) ? S_READ : S_BYP;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    ceN = 0; oeN = 1; weN = 0; addr = a; dataIn = d;
    @(negedge clk);
    ceN = 1; oeN = 1; weN = 1;
    modelWrite(a, d);
  endtask

  task automatic badStrobe(logic [ADDR_W-1:0] a, logic [7:0] d, logic c, logic o);
    @(negedge clk);
    ceN = c; oeN = o; weN = 0; addr = a; dataIn = d;
    @(negedge clk);
    ceN = 1; oeN = 1; weN = 1;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, string tag);
    @(negedge clk);
    ceN = 0; oeN = 0; weN = 1; addr = a;
    #1;
    check(tag, {31'd0, dataOutEn}, 32'd1);
    check(tag, {24'd0, dataOut}, {24'd0, expRead(a)});
    ceN = 1; oeN = 1;
  endtask

  task automatic unlock(logic [7:0] c);
    busWrite(11'h555, 8'hAA); busWrite(11'h2AA, 8'h55); busWrite(11'h555, c);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2: reset contents and mode
    busRead(11'd0, "R2 reset read");
    busRead(11'd63, "R2 reset read top");
    // R1: idle and non-read patterns stay quiet
    @(negedge clk); ceN = 1; oeN = 0; weN = 1; #1;
    check("R1 ce high quiet", {31'd0, dataOutEn}, 0);
    check("R1 ce high data", {24'd0, dataOut}, 0);
    ceN = 0; oeN = 0; weN = 0; #1;
    check("R1 we low quiet", {31'd0, dataOutEn}, 0);
    ceN = 1; oeN = 1; weN = 1;
    // R11: malformed strobes are not writes
    badStrobe(11'h555, 8'hAA, 0, 0);
    busWrite(11'h2AA, 8'h55); busWrite(11'h555, 8'h90);
    busRead(11'd0, "R11 no autoselect");
    badStrobe(11'h555, 8'hAA, 1, 1);
    busRead(11'd0, "R11 ce high write");
    // R3: identification mode
    unlock(8'h90);
    busRead(11'd0, "R3 mfr id");
    busRead(11'd1, "R3 dev id");
    busRead(11'd2, "R3 other zero");
    // R4: stays until F0
    unlock(8'hA0);
    busWrite(11'd5, 8'h00);
    busRead(11'd0, "R4 still id");
    busWrite(11'h123, 8'hF0);
    busRead(11'd0, "R4 left id");
    busRead(11'd5, "R4 no program in id");
    // R5 and R6: standard program and AND
    unlock(8'hA0); busWrite(11'd5, 8'h3C);
    busRead(11'd5, "R5 standard program");
    unlock(8'hA0); busWrite(11'd5, 8'h0F);
    busRead(11'd5, "R6 and result");
    check("R6 model", {24'd0, model[5]}, 32'h0C);
    // R9: mismatch aborts
    busWrite(11'h555, 8'hAA); busWrite(11'h2AA, 8'h55); busWrite(11'h555, 8'h33);
    busWrite(11'd6, 8'h00);
    busRead(11'd6, "R9 abort no program");
    busWrite(11'h555, 8'hAA); busWrite(11'h2AB, 8'h55); busWrite(11'h555, 8'hA0);
    busWrite(11'd6, 8'h00);
    busRead(11'd6, "R9 bad address abort");
    // R10: F0 on the data step
    unlock(8'hA0); busWrite(11'd7, 8'hF0);
    busRead(11'd7, "R10 F0 data step");
    // R7: fast-program mode
    unlock(8'h20);
    busWrite(11'd0, 8'hA0); busWrite(11'd9, 8'h12);
    busRead(11'd9, "R7 bypass program");
    // R8: F0 ignored, 90 then non-00 stays
    busWrite(11'd0, 8'hF0);
    busWrite(11'h7FF, 8'hA0); busWrite(11'd10, 8'h34);
    busRead(11'd10, "R8 F0 ignored");
    busWrite(11'd0, 8'h90); busWrite(11'd0, 8'h55);
    busWrite(11'd0, 8'hA0); busWrite(11'd12, 8'h56);
    busRead(11'd12, "R8 stays bypass");
    busWrite(11'd0, 8'h90); busWrite(11'd0, 8'h00);
    busWrite(11'd0, 8'hA0); busWrite(11'd11, 8'h00);
    busRead(11'd11, "R8 exit bypass");
    check("R8 mode model", st, S_READ);
    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [ADDR_W-1:0] ra;
      op = $urandom_range(0, 7);
      ra = ($urandom_range(0, 9) == 0) ? 11'h555 : ADDR_W'($urandom_range(0, DEPTH - 1));
      case (op)
        0, 1: busRead(ra, (st == S_AUTO) ? "R3 random id read" : "R6 random read");
        2: begin unlock(8'hA0); busWrite(ra, 8'($urandom)); end
        3: unlock(8'h20);
        4: begin busWrite(ADDR_W'($urandom), 8'hA0); busWrite(ra, 8'($urandom)); end
        5: begin busWrite(ra, 8'h90); busWrite(ra, 8'h00); end
        6: unlock(8'h90);
        default: begin
          if ($urandom_range(0, 1) == 0) busWrite(ra, 8'hF0);
          else if ($urandom_range(0, 1) == 0) busWrite(ra, 8'($urandom));
          else badStrobe(ra, 8'($urandom), 1'($urandom), 0);
        end
      endcase
    end
    finishRun();
  end
endmodule